// File: doc/BRIEF.md
# Scaled PWM Clock Generator

This block produces the per-channel clock-enable strobes that pace eight PWM channels. It takes two unscaled enable streams, A and B, from an upstream prescaler. From each it derives a slower scaled stream, SA and SB. Each scaled path runs an 8-bit down counter that reloads from its own scale register, and a halving stage follows the counter. The scaled rate is therefore the input rate divided by twice the scale value.

Each channel belongs to a fixed group. Its own select bit then picks either the group's unscaled stream or its scaled stream. Everything runs on one system clock, and every stream is a one-cycle enable strobe. Software reaches the three registers through a write-only port. Address 0 holds scale A, address 1 holds scale B, and address 2 holds the channel select byte.

Top module: `pwm_scaled_clk`

## Requirements
- R1: After reset both scale values are 0, all select bits are 0, both counters hold 256 and both halving stages are clear. With no input ticks, every channel strobe is low.
- R2: A path with scale N (1..255) makes one counter pulse every N input ticks. Its scaled strobe fires on every second pulse, so it fires every 2N input ticks. Scale 0xFF with one A tick per 4 clocks gives one SA strobe per 2040 clocks. Scale 0x01 gives one per 8 clocks.
- R3: A scale value of 0x00 acts as 256, which gives one scaled strobe per 512 input ticks.
- R4: A write to address 0 (scale A) or address 1 (scale B) reloads that path's counter in the same cycle. The first scaled strobe after the write comes on the 2N-th input tick after the write cycle, whatever the old count was.
- R5: A scale write clears that path's halving stage, so the first counter pulse after the write produces no scaled strobe.
- R6: When a scale write and a terminal count of the same path fall in one cycle, the write wins and that cycle carries no scaled strobe.
- R7: Channels 0, 1, 4 and 5 use the A/SA pair. Channels 2, 3, 6 and 7 use the B/SB pair.
- R8: The byte written to address 2 holds one select bit per channel, bit i for channel i. A 0 gives the unscaled strobe and a 1 gives the scaled strobe. A channel strobe lasts one cycle and only appears in a cycle where its group's input tick is high.
- R9: A write to address 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_a_en_i | input | 1 | Unscaled A enable strobe |
| clk_b_en_i | input | 1 | Unscaled B enable strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address (0 scale A, 1 scale B, 2 select, 3 unused) |
| wr_data_i | input | 8 | Register write data |
| ch_en_o | output | 8 | Per-channel clock-enable strobes |

## Verification
The bench measures the cycle of the first and second scaled strobe after each scale write. A counter that waits out its old count, or one that leaves the halving stage set, strobes early or late. A zero scale that is read as 0 or as 1 instead of 256 shows up as a wrong 512-tick period. A write placed on an expected strobe cycle catches a design that lets the terminal count win. The bench also counts strobes per channel, which exposes a swapped group mapping or an inverted select bit. Writes to the unused address, followed by raw-rate checks, catch a decoder that aliases address 3.

// File: rtl/pwm_sclk_pkg.sv
package pwm_sclk_pkg;
  localparam int unsigned SCL_W = 8;
  localparam int unsigned N_CH  = 8;
  localparam int unsigned ADR_W = 2;

  typedef enum logic [ADR_W-1:0] {
    ADR_SCL_A = 2'd0,
    ADR_SCL_B = 2'd1,
    ADR_SEL   = 2'd2,
    ADR_NONE  = 2'd3
  } reg_adr_e;
endpackage

// File: rtl/pwm_scale_path.sv
module pwm_scale_path #(
  parameter int unsigned SCL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_i,
  input  logic [SCL_W-1:0] wdata_i,
  output logic             scl_o
);
  localparam int unsigned CNT_W = SCL_W + 1;
  localparam logic [CNT_W-1:0] FULL = {1'b1, {SCL_W{1'b0}}};
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  function automatic logic [CNT_W-1:0] eff_f(input logic [SCL_W-1:0] v);
    return (v == '0) ? FULL : {1'b0, v};
  endfunction

  logic [SCL_W-1:0] scale_q;
  logic [CNT_W-1:0] cnt_q;
  logic             half_q;
  logic             term;

  // write beats terminal count
  assign term  = tick_i && (cnt_q == ONE) && !wr_i;
  assign scl_o = term && half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scale_q <= '0;
      cnt_q   <= FULL;
      half_q  <= 1'b0;
    end else if (wr_i) begin
      scale_q <= wdata_i;
      cnt_q   <= eff_f(wdata_i);
      half_q  <= 1'b0;
    end else if (tick_i) begin
      if (cnt_q == ONE) begin
        cnt_q  <= eff_f(scale_q);
        half_q <= ~half_q;
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end

  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) && (cnt_q <= FULL));
  p_cnt_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !wr_i) |=> $stable(cnt_q));
  p_reload_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (cnt_q == (($past(wdata_i) == '0) ? FULL : {1'b0, $past(wdata_i)})));
  p_half_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !half_q);
  p_wr_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> !scl_o);
  p_on_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_o |-> tick_i);
endmodule

// File: rtl/pwm_chan_mux.sv
module pwm_chan_mux #(
  parameter int unsigned      N_CH  = 8,
  parameter logic [N_CH-1:0]  GRP_B = 8'b1100_1100
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            a_i,
  input  logic            b_i,
  input  logic            sa_i,
  input  logic            sb_i,
  input  logic [N_CH-1:0] sel_i,
  output logic [N_CH-1:0] ch_o
);
  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    if (GRP_B[i]) begin : g_b
      assign ch_o[i] = sel_i[i] ? sb_i : b_i;
      p_grp_b_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ch_o[i] |-> b_i);
    end else begin : g_a
      assign ch_o[i] = sel_i[i] ? sa_i : a_i;
      p_grp_a_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ch_o[i] |-> a_i);
    end
  end
endmodule

// File: rtl/pwm_scaled_clk.sv
module pwm_scaled_clk
  import pwm_sclk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clk_a_en_i,
  input  logic             clk_b_en_i,
  input  logic             wr_en_i,
  input  logic [ADR_W-1:0] wr_addr_i,
  input  logic [SCL_W-1:0] wr_data_i,
  output logic [N_CH-1:0]  ch_en_o
);
  logic            wr_a, wr_b, wr_sel;
  logic            sa, sb;
  logic [N_CH-1:0] sel_q;

  assign wr_a   = wr_en_i && (wr_addr_i == ADR_SCL_A);
  assign wr_b   = wr_en_i && (wr_addr_i == ADR_SCL_B);
  assign wr_sel = wr_en_i && (wr_addr_i == ADR_SEL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= '0;
    else if (wr_sel) sel_q <= N_CH'(wr_data_i);
  end

  pwm_scale_path #(.SCL_W(SCL_W)) u_path_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(clk_a_en_i),
    .wr_i(wr_a), .wdata_i(wr_data_i), .scl_o(sa)
  );

  pwm_scale_path #(.SCL_W(SCL_W)) u_path_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(clk_b_en_i),
    .wr_i(wr_b), .wdata_i(wr_data_i), .scl_o(sb)
  );

  pwm_chan_mux #(.N_CH(N_CH), .GRP_B(8'b1100_1100)) u_mux (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_i(clk_a_en_i), .b_i(clk_b_en_i),
    .sa_i(sa), .sb_i(sb), .sel_i(sel_q), .ch_o(ch_en_o)
  );

  p_unused_adr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_addr_i == ADR_NONE)) |=> $stable(sel_q));
endmodule

// File: tb/sim_pwm_scaled_clk.sv
module sim_pwm_scaled_clk;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       a = 1'b0, b = 1'b0, wr = 1'b0;
  logic [1:0] adr = '0;
  logic [7:0] wd = '0;
  logic [7:0] ch;
  logic [7:0] smp;
  int total = 0, bad = 0, ncyc = 0;

  always #2 clk = ~clk;

  pwm_scaled_clk u0 (
    .clk_i(clk), .rst_ni(rst_n), .clk_a_en_i(a), .clk_b_en_i(b),
    .wr_en_i(wr), .wr_addr_i(adr), .wr_data_i(wd), .ch_en_o(ch)
  );

  localparam int NV = 5;
  localparam int T_SCL [NV] = '{1, 255, 0, 3, 16};
  localparam int T_PER [NV] = '{4, 4, 1, 2, 1};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // one clock: drive ticks, sample at negedge, return after next posedge
  task automatic cyc(input logic ta, input logic tb);
    a = ta; b = tb;
    @(negedge clk);
    smp = ch;
    @(posedge clk);
    #1;
    wr = 1'b0;
  endtask

  task automatic wreg(input logic [1:0] ad, input logic [7:0] d,
                      input logic ta, input logic tb);
    wr = 1'b1; adr = ad; wd = d;
    cyc(ta, tb);
  endtask

  always @(posedge clk) begin
    ncyc++;
    if (ncyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=0", ncyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #9;
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    cyc(0, 0);
    chk(smp == 8'h00, "R1 idle", smp, 8'h00);
    cyc(1, 0);
    chk(smp == 8'h33, "R1 R7 raw A", smp, 8'h33);
    cyc(0, 1);
    chk(smp == 8'hCC, "R1 R7 raw B", smp, 8'hCC);

    // table: R2 R3 R4 R5 periods after a mid-run write
    wreg(2'd2, 8'h01, 0, 0);
    for (int v = 0; v < NV; v++) begin
      automatic int n  = (T_SCL[v] == 0) ? 256 : T_SCL[v];
      automatic int p  = T_PER[v];
      automatic int f1 = -1;
      automatic int f2 = -1;
      wreg(2'd0, 8'(T_SCL[v]), 0, 0);
      for (int k = 1; k <= 4 * n * p; k++) begin
        cyc((k % p) == 0, 0);
        if (smp[0]) begin
          if (f1 < 0) f1 = k;
          else if (f2 < 0) f2 = k;
        end
      end
      chk(f1 == 2 * n * p, (T_SCL[v] == 0) ? "R3 first" : "R4 R5 first", f1, 2 * n * p);
      chk(f2 == 4 * n * p, (T_SCL[v] == 0) ? "R3 period" : "R2 period", f2, 4 * n * p);
    end

    // R7 R8 group mapping and select
    begin
      int cnt [8];
      foreach (cnt[i]) cnt[i] = 0;
      wreg(2'd2, 8'hFF, 0, 0);
      wreg(2'd0, 8'h01, 0, 0);
      wreg(2'd1, 8'h02, 0, 0);
      for (int k = 0; k < 40; k++) begin
        cyc(1, 1);
        for (int i = 0; i < 8; i++) if (smp[i]) cnt[i]++;
      end
      for (int i = 0; i < 8; i++) begin
        automatic int e = (i == 2 || i == 3 || i == 6 || i == 7) ? 10 : 20;
        chk(cnt[i] == e, "R7 R8 channel count", cnt[i], e);
      end
    end

    // R6 R5 write on a strobe cycle
    wreg(2'd2, 8'h01, 0, 0);
    wreg(2'd0, 8'h01, 0, 0);
    cyc(1, 0);
    chk(smp[0] == 1'b0, "R5 first pulse", smp[0], 0);
    cyc(1, 0);
    chk(smp[0] == 1'b1, "R2 second pulse", smp[0], 1);
    cyc(1, 0);
    wreg(2'd0, 8'h01, 1, 0);
    chk(smp[0] == 1'b0, "R6 write wins", smp[0], 0);
    cyc(1, 0);
    chk(smp[0] == 1'b0, "R5 after write", smp[0], 0);
    cyc(1, 0);
    chk(smp[0] == 1'b1, "R4 restart", smp[0], 1);

    // R9 unused address
    wreg(2'd2, 8'h00, 0, 0);
    wreg(2'd3, 8'hFF, 0, 0);
    cyc(1, 0);
    chk(smp == 8'h33, "R9 select kept", smp, 8'h33);
    cyc(1, 0);
    chk(smp == 8'h33, "R9 select kept", smp, 8'h33);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule